// File: doc/BRIEF.md
# Write Protection Decision Unit

This unit sits beside the serial command decoder of a byte-addressed nonvolatile memory and rules on every write attempt. The decoder presents a one-cycle write request together with the target (either the memory array or the status register) and the target byte address. The unit answers one clock later with a one-cycle permit pulse for the array or for the status register. A refused attempt produces no pulse, so the storage and the status register stay untouched.

The ruling combines three sources. The first is a software write-enable latch. The second is a protection-enable bit and a two-bit guarded-region code, both held in the status register. The third is an active-low hardware write-protect pin. The pin is not used directly. It is copied into the unit only when chip select becomes active, and the decision uses that copy. A pin change in the middle of a transfer therefore has no effect until the next select cycle.

Top module: `wp_guard`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `arr_wr_ok` and `sr_wr_ok` are 0. `wp_seen`, the held copy of the pin, resets to 0, which means locked.
- R2: When `wel` is 0, no request produces any permit, whatever the target, address or other inputs.
- R3: With `wel`=1 and `prot_en`=0, status register writes are permitted, and so are array writes to addresses outside the guarded region.
- R4: An array write to an address inside the guarded region is never permitted, whatever the values of `wel`, `prot_en` or the pin.
- R5: With `wel`=1, `prot_en`=1 and a held pin copy of 0, status register writes are refused and unguarded array addresses stay writable. With `guard`=11 in this state, no write of either kind is permitted.
- R6: With `wel`=1, `prot_en`=1 and a held pin copy of 1, status register writes are permitted.
- R7: The guarded region depends on `guard`. With 00 nothing is guarded. With 01 it is the addresses whose two top bits are 11 (C000h–FFFFh at 16 bits). With 10 it is the addresses whose top bit is 1 (8000h–FFFFh). With 11 it is every address.
- R8: The pin is copied on the clock where `sel_n` is sampled low after being sampled high (or after reset). The held copy then stays unchanged while `sel_n` stays low. A request in the capture cycle uses the newly captured value.
- R9: A request sampled at a clock edge yields its permit in the cycle after that edge, and for that one cycle only. No permit follows a clock where `wr_req` is 0 or `sel_n` is 1.
- R10: `arr_wr_ok` can follow only a request with `wr_to_status`=0, and `sr_wr_ok` only one with `wr_to_status`=1. The two permits are never 1 together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_n | input | 1 | Active-low chip select, sampled on clk |
| wp_n | input | 1 | Active-low hardware write-protect pin |
| wel | input | 1 | Write-enable latch |
| prot_en | input | 1 | Protection-enable bit from the status register |
| guard | input | 2 | Guarded-region code from the status register |
| wr_req | input | 1 | Write attempt strobe, one cycle per byte |
| wr_to_status | input | 1 | 1 for a status register target, 0 for an array target |
| wr_addr | input | ADDR_W | Array byte address of the attempt |
| arr_wr_ok | output | 1 | Array write permit pulse |
| sr_wr_ok | output | 1 | Status register write permit pulse |
| wp_seen | output | 1 | Pin copy held for the current select cycle |

## Verification
The pin capture and the permit decision can happen in the same cycle: a select cycle starts on the same clock as its first write attempt. The bench provokes this by dropping `sel_n` with a status request already present while the pin is high after a low-pin select cycle, and expects the permit that the new copy grants. The reverse case, where the pin drops while select stays low, must leave later permits unchanged. Every cycle is also compared against a behavioural model that applies the same rules to random inputs.

// File: rtl/wpg_pkg.sv
package wpg_pkg;

    typedef enum logic [1:0] {
        GUARD_NONE    = 2'b00,
        GUARD_QUARTER = 2'b01,
        GUARD_HALF    = 2'b10,
        GUARD_ALL     = 2'b11
    } guard_e;

    typedef struct packed {
        logic sel_prev;
        logic wp_hold;
    } pin_state_t;

    typedef struct packed {
        logic arr_ok;
        logic sr_ok;
    } permit_t;

endpackage

// File: rtl/wpg_pin_sampler.sv
module wpg_pin_sampler
    import wpg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sel_n,
    input  logic wp_n,
    output logic wp_now,
    output logic wp_held
);

    pin_state_t st_d, st_q;

    always_comb begin
        st_d          = st_q;
        st_d.sel_prev = sel_n;
        if (st_q.sel_prev && !sel_n) begin
            st_d.wp_hold = wp_n;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.sel_prev <= 1'b1;
            st_q.wp_hold  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wp_now  = st_d.wp_hold;
    assign wp_held = st_q.wp_hold;

endmodule

// File: rtl/wpg_region_decode.sv
module wpg_region_decode
    import wpg_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic [1:0]        guard,
    input  logic [ADDR_W-1:0] addr,
    output logic              guarded
);

    localparam int TOP = ADDR_W - 1;

    logic in_quarter;
    logic in_half;

    generate
        if (ADDR_W >= 2) begin : g_wide
            assign in_quarter = &addr[TOP -: 2];
            assign in_half    = addr[TOP];
        end else begin : g_narrow
            assign in_quarter = 1'b0;
            assign in_half    = addr[TOP];
        end
    endgenerate

    always_comb begin
        unique case (guard_e'(guard))
            GUARD_NONE:    guarded = 1'b0;
            GUARD_QUARTER: guarded = in_quarter;
            GUARD_HALF:    guarded = in_half;
            GUARD_ALL:     guarded = 1'b1;
            default:       guarded = 1'b1;
        endcase
    end

endmodule

// File: rtl/wpg_permit.sv
module wpg_permit
    import wpg_pkg::*;
(
    input  logic    active,
    input  logic    wr_req,
    input  logic    wr_to_status,
    input  logic    wel,
    input  logic    prot_en,
    input  logic    wp_eff,
    input  logic    guarded,
    output permit_t permit
);

    logic attempt;
    logic sr_unlocked;

    always_comb begin
        attempt       = active && wr_req && wel;
        sr_unlocked   = !prot_en || wp_eff;
        permit.arr_ok = attempt && !wr_to_status && !guarded;
        permit.sr_ok  = attempt && wr_to_status && sr_unlocked;
    end

endmodule

// File: rtl/wp_guard.sv
module wp_guard
    import wpg_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_n,
    input  logic              wp_n,
    input  logic              wel,
    input  logic              prot_en,
    input  logic [1:0]        guard,
    input  logic              wr_req,
    input  logic              wr_to_status,
    input  logic [ADDR_W-1:0] wr_addr,
    output logic              arr_wr_ok,
    output logic              sr_wr_ok,
    output logic              wp_seen
);

    logic    wp_now;
    logic    guarded;
    permit_t permit_d, permit_q;

    wpg_pin_sampler u_pin (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel_n   (sel_n),
        .wp_n    (wp_n),
        .wp_now  (wp_now),
        .wp_held (wp_seen)
    );

    wpg_region_decode #(.ADDR_W(ADDR_W)) u_region (
        .guard   (guard),
        .addr    (wr_addr),
        .guarded (guarded)
    );

    wpg_permit u_permit (
        .active       (!sel_n),
        .wr_req       (wr_req),
        .wr_to_status (wr_to_status),
        .wel          (wel),
        .prot_en      (prot_en),
        .wp_eff       (wp_now),
        .guarded      (guarded),
        .permit       (permit_d)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            permit_q <= '0;
        end else begin
            permit_q <= permit_d;
        end
    end

    assign arr_wr_ok = permit_q.arr_ok;
    assign sr_wr_ok  = permit_q.sr_ok;

endmodule

// File: rtl/wp_guard_chk.sv
module wp_guard_chk #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sel_n,
    input logic              wel,
    input logic              prot_en,
    input logic [1:0]        guard,
    input logic              wr_req,
    input logic              wr_to_status,
    input logic [ADDR_W-1:0] wr_addr,
    input logic              arr_wr_ok,
    input logic              sr_wr_ok,
    input logic              wp_seen
);

    assert_never_both_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(arr_wr_ok && sr_wr_ok));

    assert_target_match_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_to_status) |-> !arr_wr_ok);

    assert_no_latch_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wel) |-> (!arr_wr_ok && !sr_wr_ok));

    assert_all_guarded_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(guard) == 2'b11) |-> !arr_wr_ok);

    assert_sr_locked_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(prot_en) && !wp_seen) |-> !sr_wr_ok);

    assert_hold_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(sel_n) |-> $stable(wp_seen));

    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(sel_n) || !$past(wr_req)) |-> (!arr_wr_ok && !sr_wr_ok));

endmodule

bind wp_guard wp_guard_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .sel_n        (sel_n),
    .wel          (wel),
    .prot_en      (prot_en),
    .guard        (guard),
    .wr_req       (wr_req),
    .wr_to_status (wr_to_status),
    .wr_addr      (wr_addr),
    .arr_wr_ok    (arr_wr_ok),
    .sr_wr_ok     (sr_wr_ok),
    .wp_seen      (wp_seen)
);

// File: tb/wp_guard_test.sv
`timescale 1ns/1ps
module wp_guard_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel_n = 1'b1;
    logic        wp_n = 1'b1;
    logic        wel = 1'b0;
    logic        prot_en = 1'b0;
    logic [1:0]  guard = 2'b00;
    logic        wr_req = 1'b0;
    logic        wr_to_status = 1'b0;
    logic [15:0] wr_addr = 16'h0000;
    logic        arr_wr_ok, sr_wr_ok, wp_seen;

    int total = 0;
    int bad = 0;
    string tag = "R1";
    bit m_prev = 1'b1, m_hold = 1'b0, m_arr = 1'b0, m_sr = 1'b0;

    always #2.5 clk = ~clk;

    wp_guard #(.ADDR_W(16)) uut (
        .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .wp_n(wp_n), .wel(wel),
        .prot_en(prot_en), .guard(guard), .wr_req(wr_req),
        .wr_to_status(wr_to_status), .wr_addr(wr_addr),
        .arr_wr_ok(arr_wr_ok), .sr_wr_ok(sr_wr_ok), .wp_seen(wp_seen)
    );

    function automatic bit in_region(input logic [1:0] g, input int a);
        case (g)
            2'b00:   return 1'b0;
            2'b01:   return a >= 'hC000;
            2'b10:   return a >= 'h8000;
            default: return 1'b1;
        endcase
    endfunction

    // behavioural reference, updated at each rising edge
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_prev = 1'b1; m_hold = 1'b0; m_arr = 1'b0; m_sr = 1'b0;
        end else begin
            if (m_prev && !sel_n) m_hold = wp_n;
            m_prev = sel_n;
            m_arr = 1'b0; m_sr = 1'b0;
            if (!sel_n && wr_req && wel) begin
                if (wr_to_status) m_sr = !prot_en || m_hold;
                else              m_arr = !in_region(guard, int'(wr_addr));
            end
        end
    end

    task automatic chk(input string t, input logic act, input logic exp, input string what);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%b expected=%b", t, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        chk(tag, arr_wr_ok, m_arr, "model arr_wr_ok");
        chk(tag, sr_wr_ok,  m_sr,  "model sr_wr_ok");
        chk(tag, wp_seen,   m_hold, "model wp_seen");
    end

    task automatic step(input logic s, input logic w, input logic l, input logic p,
                        input logic [1:0] g, input logic r, input logic st, input logic [15:0] a);
        sel_n = s; wp_n = w; wel = l; prot_en = p; guard = g;
        wr_req = r; wr_to_status = st; wr_addr = a;
        @(posedge clk); #1;
    endtask

    initial begin
        #(5.0 * 200000);
        bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [15:0] lfsr;
        repeat (3) @(posedge clk);
        #1;
        chk("R1", arr_wr_ok, 1'b0, "reset arr"); chk("R1", sr_wr_ok, 1'b0, "reset sr");
        chk("R1", wp_seen, 1'b0, "reset pin copy");
        rst_n = 1'b1;
        @(posedge clk); #1;
        chk("R1", arr_wr_ok, 1'b0, "first cycle arr");

        tag = "R2";
        step(0, 1, 0, 0, 2'b00, 1, 0, 16'h0100); chk("R2", arr_wr_ok, 0, "wel0 arr");
        step(0, 1, 0, 0, 2'b00, 1, 1, 16'h0100); chk("R2", sr_wr_ok, 0, "wel0 sr");

        tag = "R3";
        step(0, 1, 1, 0, 2'b00, 1, 0, 16'h1234); chk("R3", arr_wr_ok, 1, "pe0 arr");
        step(0, 1, 1, 0, 2'b00, 1, 1, 16'h1234); chk("R3", sr_wr_ok, 1, "pe0 sr");
        chk("R10", arr_wr_ok, 0, "status target gives no arr");

        tag = "R7";
        step(0, 1, 1, 0, 2'b01, 1, 0, 16'hBFFF); chk("R7", arr_wr_ok, 1, "quarter BFFF");
        step(0, 1, 1, 0, 2'b01, 1, 0, 16'hC000); chk("R7", arr_wr_ok, 0, "quarter C000");
        step(0, 1, 1, 0, 2'b10, 1, 0, 16'h7FFF); chk("R7", arr_wr_ok, 1, "half 7FFF");
        step(0, 1, 1, 0, 2'b10, 1, 0, 16'h8000); chk("R7", arr_wr_ok, 0, "half 8000");
        step(0, 1, 1, 0, 2'b11, 1, 0, 16'h0000); chk("R7", arr_wr_ok, 0, "all 0000");
        tag = "R4";
        step(0, 1, 1, 1, 2'b10, 1, 0, 16'hFFFF); chk("R4", arr_wr_ok, 0, "guarded FFFF");

        tag = "R9";
        step(0, 1, 1, 0, 2'b00, 0, 0, 16'h0010); chk("R9", arr_wr_ok, 0, "no request");
        step(1, 1, 1, 0, 2'b00, 1, 0, 16'h0010); chk("R9", arr_wr_ok, 0, "deselected");

        tag = "R6";
        step(0, 1, 1, 1, 2'b00, 0, 0, 16'h0000); chk("R8", wp_seen, 1, "capture high");
        step(0, 1, 1, 1, 2'b00, 1, 1, 16'h0000); chk("R6", sr_wr_ok, 1, "pin high sr");
        step(0, 1, 1, 1, 2'b00, 0, 1, 16'h0000); chk("R9", sr_wr_ok, 0, "pulse ends");
        tag = "R8";
        step(0, 0, 1, 1, 2'b00, 1, 1, 16'h0000); chk("R8", sr_wr_ok, 1, "mid-select drop ignored");
        chk("R8", wp_seen, 1, "copy held");
        step(1, 0, 1, 1, 2'b00, 0, 1, 16'h0000);
        tag = "R5";
        step(0, 0, 1, 1, 2'b00, 1, 1, 16'h0000); chk("R5", sr_wr_ok, 0, "pin low sr");
        step(0, 0, 1, 1, 2'b00, 1, 0, 16'h0010); chk("R5", arr_wr_ok, 1, "pin low arr");
        step(0, 0, 1, 1, 2'b11, 1, 0, 16'h0000); chk("R5", arr_wr_ok, 0, "all locked arr");
        step(0, 0, 1, 1, 2'b11, 1, 1, 16'h0000); chk("R5", sr_wr_ok, 0, "all locked sr");
        tag = "R8";
        step(0, 1, 1, 1, 2'b11, 1, 1, 16'h0000); chk("R8", sr_wr_ok, 0, "rise mid-select ignored");
        step(1, 1, 1, 1, 2'b00, 0, 1, 16'h0000);
        step(0, 1, 1, 1, 2'b00, 1, 1, 16'h0000); chk("R8", sr_wr_ok, 1, "capture and decide same cycle");

        tag = "R7";
        lfsr = 16'hACE1;
        for (int i = 0; i < 3000; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step(lfsr[0] & lfsr[5], lfsr[1], lfsr[2] | lfsr[9], lfsr[3], lfsr[5:4],
                 lfsr[6] | lfsr[11], lfsr[7], {lfsr[8], lfsr[3], lfsr[13:0]});
        end

        step(1, 1, 0, 0, 2'b00, 0, 0, 16'h0000);
        @(negedge clk); #1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule